// File: doc/BRIEF.md
# Strobe Pulse Timer

This block times the active-low chip select, read strobe and write strobe of a static external memory. A 32-bit configuration word holds four byte-wide length codes. When an access is requested, the block decodes the relevant codes into cycle counts, pulls chip select and the matching data strobe low together, and releases each one when its own count runs out. A one-cycle completion pulse follows once both are released.

Each length code is non-linear. Bit 6 adds 256 cycles, bits 5:0 add 0 to 63, and bit 7 plays no part. A code that decodes to zero still gives a one-cycle pulse. Reads may run in page mode. The first read of a page is timed by the read chip-select code, and every following read of the same page by the read-strobe code, with chip select and read strobe sharing that length. A page session lasts as long as accepted requests are page-mode reads.

Top module: `strobe_pulse_timer`

## Requirements
- R1: The configuration word carries the write-strobe code in bits 7:0, the write chip-select code in bits 15:8, the read-strobe code in bits 23:16 and the read chip-select code in bits 31:24. It is written through `cfg_we`/`cfg_wdata`.
- R2: A code decodes to 256 x bit 6 plus bits 5:0 clock cycles. Bit 7 is ignored.
- R3: A code that decodes to zero produces a pulse of exactly one cycle.
- R4: A write request (`req_write`=1) holds `wr_n` low for the write-strobe length and `cs_n` low for the write chip-select length. Both fall in the cycle after the request is accepted, and `rd_n` stays high.
- R5: A read request with `req_page`=0 holds `rd_n` low for the read-strobe length and `cs_n` low for the read chip-select length. Both fall in the cycle after acceptance, and `wr_n` stays high.
- R6: The first page-mode read of a page holds both `cs_n` and `rd_n` low for the read chip-select length.
- R7: Each later page-mode read in the same page holds both `cs_n` and `rd_n` low for the read-strobe length.
- R8: An accepted request that is not a page-mode read closes the page session. The next page-mode read is then the first of a new page.
- R9: `done` is high for exactly one cycle: the first cycle in which all strobes are high again after an access. That cycle comes M cycles after the strobes fall, where M is the longer of the two pulse lengths.
- R10: A request is ignored while any strobe is low, and has no effect on strobes, lengths or the page session. A request in the `done` cycle is accepted.
- R11: The configuration word is sampled only when a request is accepted. A write in the same cycle as an accepted request applies from the next access on.
- R12: During and after a synchronous active-low reset, all strobes are high, `done` is low and no page session is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration word to store |
| req_valid | input | 1 | Access request, taken when no access is running |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_page | input | 1 | Page-mode flag, used for reads |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
Writes and standard reads are run with small distinct codes, with codes that use bit 6 (long pulses of 256 cycles and more), with bit 7 set, and with zero codes. These separate the field positions, the decode of each bit group, the one-cycle floor, and which strobe follows which code. Pairs with chip select shorter and longer than the data strobe show that each strobe is released on its own count and that `done` follows the longer one. Page-mode runs give different read chip-select and read-strobe codes, so a first access and a later access differ in length. They are broken by standard reads, writes and a reset to show where a session closes. Requests injected mid-access, and configuration writes made together with an accepted request, show that neither disturbs the running access or the session.

// File: rtl/spt_pkg.sv
// Shared types, constants and the length-code decode for the strobe pulse timer.
// Assumes one 32-bit configuration word made of four 8-bit codes.
package spt_pkg;

    localparam int FIELD_W   = 8;
    localparam int NUM_FIELD = 4;
    localparam int CFG_W     = FIELD_W * NUM_FIELD;
    localparam int LOW_W     = 6;
    localparam int LONG_STEP = 256;
    localparam int LEN_W     = $clog2(LONG_STEP + (1 << LOW_W));

    // channel indices for the counter bank
    localparam int NUM_CH = 2;
    localparam int CH_CS  = 0;
    localparam int CH_DAT = 1;

    // packed so the first member lands in the top byte
    typedef struct packed {
        logic [FIELD_W-1:0] cs_rd_code;
        logic [FIELD_W-1:0] rd_code;
        logic [FIELD_W-1:0] cs_wr_code;
        logic [FIELD_W-1:0] wr_code;
    } spt_cfg_t;

    // Turn one length code into a cycle count with a one-cycle floor.
    function automatic logic [LEN_W-1:0] pulse_len(input logic [FIELD_W-1:0] code);
        logic [LEN_W-1:0] n;
        n = LEN_W'(code[LOW_W-1:0]) + (code[LOW_W] ? LEN_W'(LONG_STEP) : '0);
        return (n == '0) ? LEN_W'(1) : n;
    endfunction

endpackage

// File: rtl/spt_cfg_reg.sv
// Holds the timing configuration word.
// Assumes a single write port. The stored value is read combinationally by the
// length selector and only matters at the moment an access is accepted.
module spt_cfg_reg
    import spt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output spt_cfg_t         cfg
);

    // store the word on a write, clear to all-zero codes on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= spt_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/spt_len_select.sv
// Chooses the chip-select and data-strobe lengths for the access being requested.
// Assumes page-mode only matters for reads. page_open says whether an earlier
// page-mode read of the same page has already been accepted.
module spt_len_select
    import spt_pkg::*;
(
    input  spt_cfg_t         cfg,
    input  logic             is_write,
    input  logic             is_page,
    input  logic             page_open,
    output logic [LEN_W-1:0] cs_len,
    output logic [LEN_W-1:0] dat_len
);

    logic [LEN_W-1:0] page_len;

    // a page-mode read uses one length for both strobes
    assign page_len = page_open ? pulse_len(cfg.rd_code) : pulse_len(cfg.cs_rd_code);

    // pick per access type
    always_comb begin
        if (is_write) begin
            cs_len  = pulse_len(cfg.cs_wr_code);
            dat_len = pulse_len(cfg.wr_code);
        end else if (is_page) begin
            cs_len  = page_len;
            dat_len = page_len;
        end else begin
            cs_len  = pulse_len(cfg.cs_rd_code);
            dat_len = pulse_len(cfg.rd_code);
        end
    end

endmodule

// File: rtl/spt_pulse_counter.sv
// Down-counter for one strobe channel.
// Assumes load only arrives while the counter is idle (count zero). active is
// high while the pulse runs; last is high in its final cycle.
module spt_pulse_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         active,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // load the length, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == W'(1));

endmodule

// File: rtl/strobe_pulse_timer.sv
// Top of the strobe pulse timer.
// Accepts a request only when no strobe is low. Drives registered active-low
// chip select, read and write strobes for the decoded lengths, and a one-cycle
// done once both channels have finished. Tracks page-mode read sessions.
module strobe_pulse_timer
    import spt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_page,
    output logic             cs_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done
);

    spt_cfg_t         cfg;
    logic [LEN_W-1:0] cs_len;
    logic [LEN_W-1:0] dat_len;
    logic [LEN_W-1:0] ch_len [NUM_CH];
    logic [NUM_CH-1:0] ch_active;
    logic [NUM_CH-1:0] ch_last;
    logic             busy;
    logic             accept;
    logic             finishing;
    logic             page_open_q;
    logic             cs_q, rd_q, wr_q, done_q;

    spt_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    spt_len_select u_sel (
        .cfg       (cfg),
        .is_write  (req_write),
        .is_page   (req_page),
        .page_open (page_open_q),
        .cs_len    (cs_len),
        .dat_len   (dat_len)
    );

    assign ch_len[CH_CS]  = cs_len;
    assign ch_len[CH_DAT] = dat_len;

    // one counter per strobe channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        spt_pulse_counter #(.W(LEN_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (accept),
            .len    (ch_len[i]),
            .active (ch_active[i]),
            .last   (ch_last[i])
        );
    end

    assign busy      = |ch_active;
    assign accept    = req_valid && !busy;
    assign finishing = busy && (&(~ch_active | ch_last));

    // chip select: low from acceptance until its counter expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
        end else if (accept) begin
            cs_q <= 1'b0;
        end else if (ch_last[CH_CS]) begin
            cs_q <= 1'b1;
        end
    end

    // data strobes: the one matching the access type goes low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else if (accept) begin
            rd_q <= req_write;
            wr_q <= !req_write;
        end else if (ch_last[CH_DAT]) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end
    end

    // done in the cycle after both channels end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finishing;
        end
    end

    // page session stays open only across accepted page-mode reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open_q <= 1'b0;
        end else if (accept) begin
            page_open_q <= req_page && !req_write;
        end
    end

    assign cs_n = cs_q;
    assign rd_n = rd_q;
    assign wr_n = wr_q;
    assign done = done_q;

endmodule

// File: rtl/spt_checker.sv
// Port-level properties of the strobe pulse timer, bound to the top module.
module spt_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic cs_n,
    input logic rd_n,
    input logic wr_n,
    input logic done
);

    // R4 R5
    one_data_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && rd_n && wr_n));

    // R9
    done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!cs_n || !rd_n || !wr_n));

    // R10
    idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cs_n && rd_n && wr_n) |=> !cs_n);

    // R10
    cs_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && (!rd_n || !wr_n)) |=> cs_n);

    // R10
    data_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rd_n && wr_n) |=> (rd_n && wr_n));

endmodule

bind strobe_pulse_timer spt_checker u_spt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
);

// File: tb/strobe_pulse_timer_test.sv
// Scoreboard bench: the driver pushes expected pulse widths, the monitor measures them.
module strobe_pulse_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_page = 1'b0;
    logic        cs_n, rd_n, wr_n, done;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] cfg_m = '0;
    bit          page_m = 1'b0;

    int    q_cs[$];
    int    q_dat[$];
    bit    q_w[$];
    string q_tag[$];

    strobe_pulse_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_page  (req_page),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .done      (done)
    );

    always #2 clk = ~clk;

    function automatic int dec(input logic [7:0] c);
        int n;
        n = (c[6] ? 256 : 0) + int'(c[5:0]);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: measure widths, compare on done
    bit in_acc = 1'b0;
    bit prev_done = 1'b0;
    int cs_c, rd_c, wr_c, cyc;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n || !rd_n || !wr_n) begin
                if (!in_acc) begin
                    in_acc = 1'b1;
                    cs_c = 0; rd_c = 0; wr_c = 0; cyc = 0;
                end
                if (!cs_n) cs_c++;
                if (!rd_n) rd_c++;
                if (!wr_n) wr_c++;
                cyc++;
            end
            if (done) begin
                check("R9", "done width", int'(prev_done), 0);
                if (q_cs.size() == 0) begin
                    check("R10", "unexpected access", 1, 0);
                end else begin
                    automatic int    ecs  = q_cs.pop_front();
                    automatic int    edat = q_dat.pop_front();
                    automatic bit    ew   = q_w.pop_front();
                    automatic string tg   = q_tag.pop_front();
                    check(tg, "cs_n width", cs_c, ecs);
                    check(tg, "rd_n width", rd_c, ew ? 0 : edat);
                    check(tg, "wr_n width", wr_c, ew ? edat : 0);
                    check("R9", "done delay", cyc, (ecs > edat) ? ecs : edat);
                end
                in_acc = 1'b0;
            end
            prev_done = done;
        end else begin
            prev_done = 1'b0;
            in_acc = 1'b0;
        end
    end

    task automatic set_cfg(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = v;
    endtask

    // driver: called at a negedge; returns at the negedge where done is seen
    task automatic run(input bit w, input bit p, input string tag,
                       input bit poke, input bit cfg_same, input logic [31:0] newcfg);
        int ecs, edat;
        if (w) begin
            ecs = dec(cfg_m[15:8]); edat = dec(cfg_m[7:0]);
        end else if (p) begin
            ecs = page_m ? dec(cfg_m[23:16]) : dec(cfg_m[31:24]);
            edat = ecs;
        end else begin
            ecs = dec(cfg_m[31:24]); edat = dec(cfg_m[23:16]);
        end
        page_m = p && !w;
        q_cs.push_back(ecs); q_dat.push_back(edat); q_w.push_back(w); q_tag.push_back(tag);
        req_valid = 1'b1; req_write = w; req_page = p;
        if (cfg_same) begin
            cfg_we = 1'b1; cfg_wdata = newcfg;
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (cfg_same) cfg_m = newcfg;
        if (poke) begin
            req_valid = 1'b1; req_write = ~w; req_page = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "cs_n in reset", int'(cs_n), 1);
        check("R12", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        page_m = 1'b0;
        check("R12", "strobes after reset", int'({cs_n, rd_n, wr_n}), 7);
        check("R12", "done after reset", int'(done), 0);
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 distinct small codes
        set_cfg(32'h05_03_02_04);
        run(1'b1, 1'b0, "R4", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R5", 1'b0, 1'b0, '0);
        run(1'b1, 1'b0, "R1", 1'b1, 1'b0, '0);
        // R2 long codes using bit 6
        set_cfg(32'h41_02_40_43);
        run(1'b1, 1'b0, "R2", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R2", 1'b0, 1'b0, '0);
        // R2 bit 7 ignored
        set_cfg(32'h85_83_C2_87);
        run(1'b1, 1'b0, "R2", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R2", 1'b0, 1'b0, '0);
        // R3 zero codes
        set_cfg(32'h00_80_00_80);
        run(1'b1, 1'b0, "R3", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R3", 1'b1, 1'b0, '0);
        // R4 chip select shorter than the write strobe
        set_cfg(32'h01_09_01_06);
        run(1'b1, 1'b0, "R4", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R5", 1'b0, 1'b0, '0);
        // page sessions
        set_cfg(32'h07_02_03_03);
        run(1'b0, 1'b1, "R6", 1'b0, 1'b0, '0);
        run(1'b0, 1'b1, "R7", 1'b0, 1'b0, '0);
        run(1'b0, 1'b1, "R7", 1'b1, 1'b0, '0);
        run(1'b0, 1'b1, "R10", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R8", 1'b0, 1'b0, '0);
        run(1'b0, 1'b1, "R8", 1'b0, 1'b0, '0);
        run(1'b0, 1'b1, "R7", 1'b0, 1'b0, '0);
        run(1'b1, 1'b1, "R8", 1'b0, 1'b0, '0);
        run(1'b0, 1'b1, "R8", 1'b0, 1'b0, '0);
        // R11 configuration write together with an accepted request
        run(1'b1, 1'b0, "R11", 1'b0, 1'b1, 32'h0A_05_08_02);
        run(1'b1, 1'b0, "R11", 1'b0, 1'b0, '0);
        run(1'b0, 1'b0, "R11", 1'b0, 1'b0, '0);
        // R12 reset closes a page session
        run(1'b0, 1'b1, "R6", 1'b0, 1'b0, '0);
        @(negedge clk);
        do_reset();
        set_cfg(32'h0A_05_08_02);
        run(1'b0, 1'b1, "R12", 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        check("R9", "pending accesses", q_cs.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule